// File: doc/BRIEF.md
# Programmable MASH Divide-Ratio Sequencer

This block drives the multimodulus divider of a fractional-N PLL. Once per reference clock it emits the divide ratio for the next divider cycle. Over time the ratios average to an integer base plus a programmable fraction K/F. The fraction comes from a cascade of three first-order accumulators, each of which emits only a one-bit carry. The carries are delayed so that they line up. The aligned six-bit carry pattern then indexes a precomputed coefficient table, which avoids an adder chain. The table output is a signed offset in the range -3 to +4. The offset is added to the base ratio, clamped to the divider range, and registered.

The noise-shaping order is selectable from integer-only up to third order. Each accumulator starts from its own seed, which breaks up short periodic patterns. The configuration comes from input ports and is captured only on a synchronous load strobe. The strobe also seeds the accumulators and empties the carry pipeline. A small controller has two states. ST_IDLE is entered at reset: nothing steps and the ratio is fixed at 64. ST_RUN is where the cascade steps. ST_IDLE goes to ST_RUN on load. ST_RUN stays in ST_RUN on load, which reloads. No transition leaves ST_RUN except reset.

Top module: `mash_divratio_gen`

## Requirements
- R1: After reset, the controller is in ST_IDLE and div_ratio is 64. No accumulator steps and div_ratio stays 64 until the first load strobe.
- R2: On a clock edge where load is 1, the block does all of the following: it captures int_word, frac_word, modulus and order_sel; it sets the stage 1, 2 and 3 accumulators to seed1, seed2 and seed3; it clears every carry and carry-delay register; and it enters ST_RUN. On the next edge, div_ratio becomes 64 + int_word with a zero offset.
- R3: Configuration and seed inputs have no effect on any edge where load is 0.
- R4: On each step, stage 1 computes acc1 + K. If the sum is F or more, F is subtracted and the carry is 1. Otherwise the carry is 0. The accumulator always stays below F. F may be 1 to 64. K and the seeds must be below F.
- R5: Stage 2 adds the previous registered value of acc1 using the same rule as R4. Stage 3 adds the previous registered value of acc2 in the same way.
- R6: The order_sel value sets how many stages are enabled. A value of 0 enables no stages, 1 enables stage 1, 2 enables stages 1 and 2, and 3 enables all three stages. A disabled stage holds its seed and its registered carry is 0.
- R7: Let c1, c2 and c3 be the registered carries. Let d1 mean a delay of one cycle and d2 a delay of two cycles. The offset is c1.d2 + c2.d1 − c2.d2 + c3 − 2·c3.d1 + c3.d2, looked up from a 64-entry table indexed by {c1.d2, c2.d1, c2.d2, c3, c3.d1, c3.d2}. The offset always lies between −3 and +4.
- R8: On every edge, div_ratio is loaded with 64 + the captured int_word + the offset, clamped to the range 64 to 127.
- R9: When no clamping occurs, the average of div_ratio over any window of 4·F cycles is within 4/F·(1/4) of 64 + N + K/F. In integer form this is |F·sum − F·L·(64+N) − L·K| ≤ 4F for a window of L = 4F cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that captures the configuration and seeds |
| int_word | input | 6 | Base ratio above 64 (N) |
| frac_word | input | 6 | Fractional increment K |
| modulus | input | 7 | Accumulator modulus F, 1 to 64 |
| order_sel | input | 2 | Number of enabled stages, 0 to 3 |
| seed1 | input | 6 | Start value for stage 1 |
| seed2 | input | 6 | Start value for stage 2 |
| seed3 | input | 6 | Start value for stage 3 |
| div_ratio | output | 7 | Registered divide ratio, 64 to 127 |

## Verification
Some properties are checked on every cycle by assertions. These are: each active accumulator stays below F; a disabled stage yields a zero carry; the table offset stays within −3 to +4; div_ratio never leaves 64 to 127 and is 64 while idle; and the captured configuration holds when no load strobe is present. The exact ratio sequences for each order, the modulus, seed and carry alignment behind them, and the long-run average can only be shown by the bench's scenarios. Those scenarios sweep the order, K, F and seed values and compare every output against an arithmetic model.

// File: rtl/mash_pkg.sv
package mash_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fsm_state_t;

    localparam int NUM_STAGES = 3;
    localparam int COEF_W     = 4;
    localparam int PAT_W      = 6;
    localparam int TBL_SIZE   = 1 << PAT_W;
endpackage

// File: rtl/mash_ctrl.sv
module mash_ctrl
    import mash_pkg::*;
#(
    parameter int N_W   = 6,
    parameter int ACC_W = 6,
    parameter int F_W   = ACC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_W-1:0]   n_in,
    input  logic [ACC_W-1:0] k_in,
    input  logic [F_W-1:0]   f_in,
    input  logic [1:0]       ord_in,
    output logic [N_W-1:0]   cfg_n,
    output logic [ACC_W-1:0] cfg_k,
    output logic [F_W-1:0]   cfg_f,
    output logic [1:0]       cfg_ord,
    output logic             running
);
    fsm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_n   <= '0;
            cfg_k   <= '0;
            cfg_f   <= F_W'(1);
            cfg_ord <= '0;
        end else if (load) begin
            cfg_n   <= n_in;
            cfg_k   <= k_in;
            cfg_f   <= f_in;
            cfg_ord <= ord_in;
        end
    end

    // R3: captured configuration only moves on a load strobe
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cfg_n) && $stable(cfg_k) && $stable(cfg_f) && $stable(cfg_ord)));

    // R2: a load strobe always leaves the controller running
    assert_load_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running);
endmodule

// File: rtl/mash_stage.sv
module mash_stage #(
    parameter int ACC_W = 6,
    parameter int F_W   = ACC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             enable,
    input  logic [ACC_W-1:0] seed,
    input  logic [F_W-1:0]   modulus,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry_q
);
    logic [ACC_W:0] sum;
    logic           wrap;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, addend};
        wrap = (sum >= modulus);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (load) begin
            acc_q   <= seed;
            carry_q <= 1'b0;
        end else if (enable) begin
            acc_q   <= wrap ? ACC_W'(sum - modulus) : ACC_W'(sum);
            carry_q <= wrap;
        end else begin
            carry_q <= 1'b0;
        end
    end

    // R4: an active accumulator never reaches its modulus
    assert_acc_below_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load) |-> ({1'b0, acc_q} < modulus));

    // R6: a disabled stage produces no carry
    assert_off_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !carry_q);
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
    import mash_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     c1,
    input  logic                     c2,
    input  logic                     c3,
    output logic signed [COEF_W-1:0] offset
);
    logic c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2;
    logic [PAT_W-1:0] pat;
    logic signed [COEF_W-1:0] coef_rom [TBL_SIZE];

    for (genvar i = 0; i < TBL_SIZE; i++) begin : g_rom
        localparam int VAL = ((i >> 5) & 1) + ((i >> 4) & 1) - ((i >> 3) & 1)
                           + ((i >> 2) & 1) - 2 * ((i >> 1) & 1) + (i & 1);
        assign coef_rom[i] = COEF_W'(VAL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            c1_d1 <= 1'b0; c1_d2 <= 1'b0;
            c2_d1 <= 1'b0; c2_d2 <= 1'b0;
            c3_d1 <= 1'b0; c3_d2 <= 1'b0;
        end else begin
            c1_d1 <= c1;    c1_d2 <= c1_d1;
            c2_d1 <= c2;    c2_d2 <= c2_d1;
            c3_d1 <= c3;    c3_d2 <= c3_d1;
        end
    end

    always_comb begin
        pat    = {c1_d2, c2_d1, c2_d2, c3, c3_d1, c3_d2};
        offset = coef_rom[pat];
    end

    // R7: table offset bounded to the third-order span
    assert_offset_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (offset >= -4'sd3) && (offset <= 4'sd4));
endmodule

// File: rtl/mash_divratio_gen.sv
module mash_divratio_gen
    import mash_pkg::*;
#(
    parameter int N_W   = 6,
    parameter int ACC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [N_W-1:0]     int_word,
    input  logic [ACC_W-1:0]   frac_word,
    input  logic [ACC_W:0]     modulus,
    input  logic [1:0]         order_sel,
    input  logic [ACC_W-1:0]   seed1,
    input  logic [ACC_W-1:0]   seed2,
    input  logic [ACC_W-1:0]   seed3,
    output logic [N_W:0]       div_ratio
);
    localparam int F_W     = ACC_W + 1;
    localparam int OUT_W   = N_W + 1;
    localparam int DIV_MIN = 1 << N_W;
    localparam int DIV_MAX = (1 << OUT_W) - 1;

    logic [N_W-1:0]   cfg_n;
    logic [ACC_W-1:0] cfg_k;
    logic [F_W-1:0]   cfg_f;
    logic [1:0]       cfg_ord;
    logic             running;

    logic [ACC_W-1:0] acc   [NUM_STAGES];
    logic [ACC_W-1:0] seeds [NUM_STAGES];
    logic             carry [NUM_STAGES];
    logic signed [COEF_W-1:0] offset;
    int               total;
    logic [OUT_W-1:0] ratio_d;

    assign seeds[0] = seed1;
    assign seeds[1] = seed2;
    assign seeds[2] = seed3;

    mash_ctrl #(.N_W(N_W), .ACC_W(ACC_W), .F_W(F_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load),
        .n_in(int_word), .k_in(frac_word), .f_in(modulus), .ord_in(order_sel),
        .cfg_n(cfg_n), .cfg_k(cfg_k), .cfg_f(cfg_f), .cfg_ord(cfg_ord),
        .running(running)
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic             en;
        logic [ACC_W-1:0] add_in;
        assign en = running && (int'(cfg_ord) > s);
        if (s == 0) begin : g_first
            assign add_in = cfg_k;
        end else begin : g_next
            assign add_in = acc[s-1];
        end
        mash_stage #(.ACC_W(ACC_W), .F_W(F_W)) u_stage (
            .clk(clk), .rst_n(rst_n), .load(load), .enable(en),
            .seed(seeds[s]), .modulus(cfg_f), .addend(add_in),
            .acc_q(acc[s]), .carry_q(carry[s])
        );
    end

    mash_combiner u_comb (
        .clk(clk), .rst_n(rst_n), .load(load),
        .c1(carry[0]), .c2(carry[1]), .c3(carry[2]),
        .offset(offset)
    );

    always_comb begin
        total = DIV_MIN + int'(cfg_n) + int'(offset);
        if (total < DIV_MIN)      ratio_d = OUT_W'(DIV_MIN);
        else if (total > DIV_MAX) ratio_d = OUT_W'(DIV_MAX);
        else                      ratio_d = OUT_W'(total);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_ratio <= OUT_W'(DIV_MIN);
        else        div_ratio <= ratio_d;
    end

    // R8: the ratio never leaves the divider range
    assert_ratio_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(div_ratio) >= DIV_MIN) && (int'(div_ratio) <= DIV_MAX));

    // R1: no fractional activity before the first load
    assert_idle_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (int'(div_ratio) == DIV_MIN));
endmodule

// File: tb/mash_divratio_gen_test.sv
module mash_divratio_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       load;
    logic [5:0] int_word, frac_word, seed1, seed2, seed3;
    logic [6:0] modulus;
    logic [1:0] order_sel;
    logic [6:0] div_ratio;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    int m_run, m_n, m_k, m_f, m_ord, m_out;
    int m_acc [3];
    int m_c   [3];
    int m_d1  [3];
    int m_d2  [3];

    always #5 clk = ~clk;

    mash_divratio_gen uut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .int_word(int_word), .frac_word(frac_word), .modulus(modulus),
        .order_sel(order_sel), .seed1(seed1), .seed2(seed2), .seed3(seed3),
        .div_ratio(div_ratio)
    );

    task automatic check(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_n = 0; m_k = 0; m_f = 1; m_ord = 0; m_out = 64;
        for (int i = 0; i < 3; i++) begin
            m_acc[i] = 0; m_c[i] = 0; m_d1[i] = 0; m_d2[i] = 0;
        end
    endtask

    task automatic model_step();
        int off, tot;
        int old_acc [3];
        off = m_d2[0] + m_d1[1] - m_d2[1] + m_c[2] - 2 * m_d1[2] + m_d2[2];
        tot = 64 + m_n + off;
        if (tot < 64) tot = 64;
        if (tot > 127) tot = 127;
        if (load) begin
            m_n = int'(int_word); m_k = int'(frac_word);
            m_f = int'(modulus);  m_ord = int'(order_sel);
            m_acc[0] = int'(seed1); m_acc[1] = int'(seed2); m_acc[2] = int'(seed3);
            for (int i = 0; i < 3; i++) begin
                m_c[i] = 0; m_d1[i] = 0; m_d2[i] = 0;
            end
            m_run = 1;
        end else begin
            for (int i = 0; i < 3; i++) begin
                m_d2[i] = m_d1[i];
                m_d1[i] = m_c[i];
                old_acc[i] = m_acc[i];
            end
            for (int i = 0; i < 3; i++) begin
                if (m_run == 1 && m_ord > i) begin
                    int s;
                    s = old_acc[i] + ((i == 0) ? m_k : old_acc[i-1]);
                    if (s >= m_f) begin m_acc[i] = s - m_f; m_c[i] = 1; end
                    else          begin m_acc[i] = s;       m_c[i] = 0; end
                end else begin
                    m_c[i] = 0;
                end
            end
        end
        m_out = tot;
    endtask

    task automatic tick(input string req, input bit do_chk);
        model_step();
        @(posedge clk);
        @(negedge clk);
        if (do_chk) check(req, int'(div_ratio), m_out);
    endtask

    task automatic run_case(input int n, input int k, input int f, input int ord,
                            input int s1, input int s2, input int s3, input bit avg);
        int sum, len;
        string tag;
        case (ord)
            0: tag = "R2 R6 R8";
            1: tag = "R4 R6 R7 R8";
            2: tag = "R5 R6 R7 R8";
            default: tag = "R5 R7 R8";
        endcase
        int_word = 6'(n); frac_word = 6'(k); modulus = 7'(f); order_sel = 2'(ord);
        seed1 = 6'(s1); seed2 = 6'(s2); seed3 = 6'(s3);
        load = 1'b1;
        tick("R2 load edge", 1'b1);
        load = 1'b0;
        // scramble inputs without a strobe: must be ignored (R3)
        int_word = ~int_word; frac_word = 6'(n); modulus = 7'(64);
        order_sel = ~order_sel; seed1 = ~seed1; seed2 = ~seed2; seed3 = ~seed3;
        tick("R2 first ratio", 1'b0);
        check("R2 first ratio", int'(div_ratio), 64 + n);
        for (int c = 0; c < 4; c++) tick({tag, " R3"}, 1'b1);
        len = 4 * f;
        sum = 0;
        for (int c = 0; c < len; c++) begin
            tick(tag, 1'b1);
            sum += int'(div_ratio);
        end
        if (avg) begin
            int diff;
            diff = f * sum - f * len * (64 + n) - len * ((ord == 0) ? 0 : k);
            n_vec++;
            if (diff > 4 * f || diff < -4 * f) begin
                n_bad++;
                $display("FAIL R9: weighted error %0d expected within +-%0d", diff, 4 * f);
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int fl [4];
        fl[0] = 5; fl[1] = 7; fl[2] = 30; fl[3] = 64;
        rst_n = 1'b0; load = 1'b0;
        int_word = '0; frac_word = '0; modulus = 7'(1); order_sel = '0;
        seed1 = '0; seed2 = '0; seed3 = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset ratio", int'(div_ratio), 64);
        // configuration wiggles with no strobe: stays idle (R1, R3)
        int_word = 6'd40; frac_word = 6'd3; modulus = 7'd7; order_sel = 2'd3;
        seed1 = 6'd1; seed2 = 6'd2; seed3 = 6'd4;
        for (int c = 0; c < 6; c++) tick("R1 R3 idle", 1'b1);

        // sweep of order, modulus, increment and seeds
        for (int fi = 0; fi < 4; fi++) begin
            for (int ord = 0; ord < 4; ord++) begin
                for (int kv = 0; kv < 4; kv++) begin
                    int f, k;
                    f = fl[fi];
                    case (kv)
                        0: k = 0;
                        1: k = (f > 1) ? 1 : 0;
                        2: k = f / 2;
                        default: k = f - 1;
                    endcase
                    run_case(20 + kv, k, f, ord, (kv * 3) % f, (kv + ord) % f,
                             (fi + 2 * kv) % f, 1'b1);
                end
            end
        end

        // divider range limits in third order (R8)
        run_case(0,  3, 7,  3, 6, 5, 4, 1'b0);
        run_case(63, 4, 7,  3, 0, 6, 1, 1'b0);
        run_case(0,  31, 64, 3, 63, 0, 17, 1'b0);
        run_case(63, 33, 64, 3, 1, 62, 9, 1'b0);
        // modulus of one: fraction is always zero (R4)
        run_case(10, 0, 1, 3, 0, 0, 0, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule